// File: doc/BRIEF.md
# Supply-Pulse Trim Programming Sequencer

This block decodes a one-wire trim programming protocol that arrives on a supply pin as three voltage levels. Off-chip comparators reduce the pin voltage to a 2-bit level code every clock. The block measures each pulse, recognises a direction key and a programming key, counts address pulses, and writes one-time fuse bits. The fuses are modelled as sticky register bits, and one of them is a lock that freezes the rest.

A programming station first sweeps the live address to find the right switch point, reading the address outputs as it goes. It then burns the result one bit per enable cycle. Each burn is an enable key, an address equal to the bit's binary weight, and a long high pulse. The polarity fuse is burned straight after an enable key that was itself preceded by the direction key. The lock fuse sits one address beyond the largest code.

Top module: `trim_prog_seq`

## Requirements
- R1: Level codes are 00 zero, 01 low, 10 mid, 11 high. A pulse is a run of mid/high cycles between low cycles. The pulse counts only if it lasted at least MIN_ON cycles and was preceded by at least MIN_OFF low cycles. It is a high pulse if any of its cycles was high, otherwise it is a mid pulse. It takes effect at the clock edge that first samples low after it.
- R2: From idle, a high pulse selects address 1 and each later mid pulse adds one. The address saturates at 2^CODE_W (128 by default).
- R3: A high pulse, then 1 to 6 mid pulses, then a high pulse, all from idle, sets the negative direction and selects address 1.
- R4: A high pulse followed by at least 7 mid pulses and another high pulse enables programming. The address returns to 0 and the direction is kept.
- R5: No fuse changes unless a long high pulse (on-time at least LONG cycles) arrives while programming is enabled. After such a pulse the sequencer returns to idle with address 0 and positive direction.
- R6: While enabled, a short high pulse selects address 1 and mid pulses advance it. A long high pulse at address 2^i (i below CODE_W) sets code fuse bit i. Any other code address writes nothing.
- R7: A long high pulse directly after the enable key sets the polarity fuse when the direction is negative, and writes nothing when it is positive.
- R8: A long high pulse at address 2^CODE_W sets the lock fuse. Once the lock is set, no fuse changes again.
- R9: Fuse bits are cleared only by reset and otherwise never return to 0.
- R10: A zero level at any time aborts the sequence: idle, address 0, positive direction. The fuses are kept.
- R11: While enabled, a high pulse of at least MIN_ON but fewer than LONG cycles only selects an address and does not write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears fuses |
| sup_lvl | input | 2 | Supply level code from comparators |
| addr | output | CODE_W+1 | Live address |
| addr_neg | output | 1 | Address direction is negative |
| fuse_code | output | CODE_W | Code fuse bits |
| fuse_pol | output | 1 | Polarity fuse |
| fuse_lock | output | 1 | Lock fuse |

## Verification
The lock fuse sits at the far end of the address range. Reaching it takes a valid enable key, a selecting high pulse and 127 counted mid pulses, each with correct on and off times, before the long pulse. The stimulus builds this from one pulse task. It then retries a burn after the lock to show the freeze. The short-gap discard needs a pulse that is valid in itself but follows too few low cycles, and the bench drives exactly such a pair.

// File: rtl/trim_prog_pkg.sv
package trim_prog_pkg;
  typedef enum logic [1:0] {
    LVL_ZERO = 2'b00,
    LVL_LOW  = 2'b01,
    LVL_MID  = 2'b10,
    LVL_HIGH = 2'b11
  } lvl_e;

  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for an opening high pulse
    ST_HEAD,   // first segment after the opening high
    ST_ADDR,   // later segments, not enabled
    ST_ENA,    // enabled, no address selected yet
    ST_EADDR   // enabled, addressing
  } seq_st_e;

  // cycles for a given duration at a clock rate given in kHz, at least 1
  function automatic int us_to_cycles(input int khz, input int us);
    int c;
    c = (khz * us) / 1000;
    return (c < 1) ? 1 : c;
  endfunction
endpackage

// File: rtl/trim_pulse_meter.sv
module trim_pulse_meter #(
  parameter int MIN_ON  = 4,
  parameter int MIN_OFF = 4,
  parameter int LONG    = 20,
  localparam int CW     = $clog2(LONG + 2)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sup_lvl,
  output logic       ev_mid,
  output logic       ev_high,
  output logic       ev_long,
  output logic       abort
);
  import trim_prog_pkg::*;

  logic          in_q, pk_q, gap_q;
  logic [CW-1:0] on_q, off_q;

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v, input int lim);
    return (int'(v) >= lim) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q <= 1'b0; pk_q <= 1'b0; gap_q <= 1'b0;
      on_q <= '0;   off_q <= '0;
    end else begin
      case (lvl_e'(sup_lvl))
        LVL_ZERO: begin
          in_q <= 1'b0; on_q <= '0; off_q <= '0;
        end
        LVL_LOW: begin
          in_q  <= 1'b0;
          off_q <= in_q ? CW'(1) : sat_inc(off_q, MIN_OFF);
        end
        default: begin
          if (!in_q) begin
            in_q  <= 1'b1;
            on_q  <= CW'(1);
            pk_q  <= (sup_lvl == LVL_HIGH);
            gap_q <= (int'(off_q) >= MIN_OFF);
          end else begin
            on_q <= sat_inc(on_q, LONG);
            if (sup_lvl == LVL_HIGH) pk_q <= 1'b1;
          end
        end
      endcase
    end
  end

  logic ev_ok;
  assign ev_ok   = in_q && (sup_lvl == LVL_LOW) && (int'(on_q) >= MIN_ON) && gap_q;
  assign ev_high = ev_ok && pk_q;
  assign ev_mid  = ev_ok && !pk_q;
  assign ev_long = int'(on_q) >= LONG;
  assign abort   = (sup_lvl == LVL_ZERO);

  AST_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_mid, ev_high})); // R1
  AST_ABORT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (on_q == '0) && !in_q); // R10
endmodule

// File: rtl/trim_key_seq.sv
module trim_key_seq #(
  parameter int CODE_W   = 7,
  parameter int KEY_MIDS = 7,
  parameter int POL_MAX  = 6,
  localparam int AW      = CODE_W + 1,
  localparam int FW      = CODE_W + 2,
  localparam int MW      = $clog2(KEY_MIDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_mid,
  input  logic          ev_high,
  input  logic          ev_long,
  input  logic          abort,
  output logic [AW-1:0] addr,
  output logic          addr_neg,
  output logic          wr_en,
  output logic [FW-1:0] wr_mask
);
  import trim_prog_pkg::*;

  localparam logic [AW-1:0] LOCK_ADDR = AW'(1) << CODE_W;

  seq_st_e       st_q;
  logic [AW-1:0] addr_q;
  logic [MW-1:0] mids_q;
  logic          neg_q;

  logic enabled, key_en, key_pol;
  assign enabled = (st_q == ST_ENA) || (st_q == ST_EADDR);
  assign key_en  = int'(mids_q) >= KEY_MIDS;
  assign key_pol = (mids_q != '0) && (int'(mids_q) <= POL_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; addr_q <= '0; mids_q <= '0; neg_q <= 1'b0;
    end else if (abort || (ev_high && ev_long && enabled)) begin
      st_q <= ST_IDLE; addr_q <= '0; mids_q <= '0; neg_q <= 1'b0;
    end else if (ev_mid) begin
      if (st_q != ST_IDLE && st_q != ST_ENA) begin
        if (addr_q != LOCK_ADDR) addr_q <= addr_q + 1'b1;
        if (!key_en) mids_q <= mids_q + 1'b1;
      end
    end else if (ev_high) begin
      mids_q <= '0;
      addr_q <= AW'(1);
      case (st_q)
        ST_IDLE: st_q <= ST_HEAD;
        ST_HEAD, ST_ADDR: begin
          if (key_en) begin
            st_q <= ST_ENA; addr_q <= '0;
          end else if (st_q == ST_HEAD && key_pol) begin
            st_q <= ST_ADDR; neg_q <= 1'b1;
          end
        end
        default: st_q <= ST_EADDR; // short high while enabled
      endcase
    end
  end

  // one fuse per code address 2^i, lock at LOCK_ADDR, polarity when unaddressed
  logic [FW-1:0] addr_mask;
  for (genvar i = 0; i < CODE_W; i++) begin : g_bit
    assign addr_mask[i] = (addr_q == (AW'(1) << i));
  end
  assign addr_mask[CODE_W]   = 1'b0;
  assign addr_mask[CODE_W+1] = (addr_q == LOCK_ADDR);

  assign wr_en   = ev_high && ev_long && enabled;
  assign wr_mask = (st_q == ST_ENA) ? (FW'(neg_q) << CODE_W) : addr_mask;
  assign addr     = addr_q;
  assign addr_neg = neg_q;

  AST_ADDR_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    addr_q <= LOCK_ADDR); // R2
  AST_ABORT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (addr_q == '0) && !neg_q); // R10
  AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $onehot0(wr_mask)); // R6
endmodule

// File: rtl/trim_fuse_bank.sv
module trim_fuse_bank #(
  parameter int FW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [FW-1:0] wr_mask,
  output logic [FW-1:0] fuse
);
  logic [FW-1:0] fuse_q;
  logic          locked;
  assign locked = fuse_q[FW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                fuse_q <= '0;
    else if (wr_en && !locked) fuse_q <= fuse_q | wr_mask;
  end
  assign fuse = fuse_q;

  AST_FUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((fuse_q & $past(fuse_q)) == $past(fuse_q))); // R9
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(fuse_q)); // R8
  AST_NO_WR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(fuse_q)); // R5
endmodule

// File: rtl/trim_prog_seq.sv
module trim_prog_seq #(
  parameter int CLK_KHZ  = 200,
  parameter int ON_US    = 20,
  parameter int OFF_US   = 20,
  parameter int LONG_US  = 100,
  parameter int CODE_W   = 7,
  parameter int KEY_MIDS = 7,
  parameter int POL_MAX  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        sup_lvl,
  output logic [CODE_W:0]   addr,
  output logic              addr_neg,
  output logic [CODE_W-1:0] fuse_code,
  output logic              fuse_pol,
  output logic              fuse_lock
);
  import trim_prog_pkg::*;

  localparam int MIN_ON  = us_to_cycles(CLK_KHZ, ON_US);
  localparam int MIN_OFF = us_to_cycles(CLK_KHZ, OFF_US);
  localparam int LONG    = us_to_cycles(CLK_KHZ, LONG_US);
  localparam int FW      = CODE_W + 2;

  logic          ev_mid, ev_high, ev_long, abort, wr_en;
  logic [FW-1:0] wr_mask, fuse;

  trim_pulse_meter #(.MIN_ON(MIN_ON), .MIN_OFF(MIN_OFF), .LONG(LONG)) u_meter (
    .clk(clk), .rst_n(rst_n), .sup_lvl(sup_lvl),
    .ev_mid(ev_mid), .ev_high(ev_high), .ev_long(ev_long), .abort(abort));

  trim_key_seq #(.CODE_W(CODE_W), .KEY_MIDS(KEY_MIDS), .POL_MAX(POL_MAX)) u_seq (
    .clk(clk), .rst_n(rst_n), .ev_mid(ev_mid), .ev_high(ev_high),
    .ev_long(ev_long), .abort(abort), .addr(addr), .addr_neg(addr_neg),
    .wr_en(wr_en), .wr_mask(wr_mask));

  trim_fuse_bank #(.FW(FW)) u_fuse (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mask(wr_mask), .fuse(fuse));

  assign fuse_code = fuse[CODE_W-1:0];
  assign fuse_pol  = fuse[CODE_W];
  assign fuse_lock = fuse[CODE_W+1];
endmodule

// File: tb/trim_prog_seq_bench.sv
module trim_prog_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sup_lvl = 2'b00;
  logic [7:0] addr;
  logic       addr_neg, fuse_pol, fuse_lock;
  logic [6:0] fuse_code;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  trim_prog_seq u_trim_prog_seq (
    .clk(clk), .rst_n(rst_n), .sup_lvl(sup_lvl), .addr(addr), .addr_neg(addr_neg),
    .fuse_code(fuse_code), .fuse_pol(fuse_pol), .fuse_lock(fuse_lock));

  localparam int Z = 0, L = 1, M = 2, H = 3;
  localparam int T_ON = 4, T_OFF = 4, T_LONG = 20;

  // behavioural reference: run lengths and a phase number
  int  run_on, run_off, phase, m_addr, seg_mids;
  bit  running, saw_high, gap_good, m_neg, m_pol, m_lock;
  bit  [6:0] m_code;
  bit  got_mid, got_high, was_long;

  always @(posedge clk) begin
    if (!rst_n) begin
      run_on = 0; run_off = 0; phase = 0; m_addr = 0; seg_mids = 0;
      running = 0; saw_high = 0; gap_good = 0; m_neg = 0;
      m_pol = 0; m_lock = 0; m_code = '0;
    end else begin
      got_mid = 0; got_high = 0; was_long = (run_on >= T_LONG);
      if (sup_lvl == Z) begin
        running = 0; run_on = 0; run_off = 0;
        phase = 0; m_addr = 0; m_neg = 0; seg_mids = 0;
      end else if (sup_lvl == L) begin
        if (running && run_on >= T_ON && gap_good) begin
          got_high = saw_high; got_mid = !saw_high;
        end
        run_off = running ? 1 : run_off + 1;
        running = 0;
      end else begin
        if (!running) begin
          gap_good = (run_off >= T_OFF); running = 1; run_on = 1; saw_high = (sup_lvl == H);
        end else begin
          run_on++; if (sup_lvl == H) saw_high = 1;
        end
      end
      if (got_mid && phase != 0 && phase != 3) begin
        if (m_addr < 128) m_addr++;
        seg_mids++;
      end
      if (got_high) begin
        if ((phase == 3 || phase == 4) && was_long) begin
          if (!m_lock) begin
            if (phase == 3) begin if (m_neg) m_pol = 1; end
            else if (m_addr == 128) m_lock = 1;
            else for (int i = 0; i < 7; i++) if (m_addr == (1 << i)) m_code[i] = 1;
          end
          phase = 0; m_addr = 0; m_neg = 0; seg_mids = 0;
        end else begin
          if ((phase == 1 || phase == 2) && seg_mids >= 7) begin
            phase = 3; m_addr = 0;
          end else begin
            if (phase == 1 && seg_mids >= 1 && seg_mids <= 6) begin phase = 2; m_neg = 1; end
            else if (phase == 0) phase = 1;
            else if (phase == 3) phase = 4;
            m_addr = 1;
          end
          seg_mids = 0;
        end
      end
    end
  end

  // per-clock comparison against the reference (R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 R11)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      tests++;
      if (addr !== 8'(m_addr) || addr_neg !== m_neg || fuse_code !== m_code ||
          fuse_pol !== m_pol || fuse_lock !== m_lock) begin
        fails++;
        $display("FAIL trace model R1..R11 at %0t: act addr=%0d neg=%0b code=%0h pol=%0b lock=%0b exp addr=%0d neg=%0b code=%0h pol=%0b lock=%0b",
                 $time, addr, addr_neg, fuse_code, fuse_pol, fuse_lock,
                 m_addr, m_neg, m_code, m_pol, m_lock);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(input int k, input int on, input int off);
    @(negedge clk) sup_lvl = 2'(k);
    repeat (on - 1) @(negedge clk);
    @(negedge clk) sup_lvl = 2'(L);
    repeat (off - 1) @(negedge clk);
  endtask

  task automatic mids(input int n);
    for (int i = 0; i < n; i++) pulse(M, 6, 6);
  endtask

  task automatic drop();
    @(negedge clk) sup_lvl = 2'(Z);
    repeat (2) @(negedge clk);
    @(negedge clk) sup_lvl = 2'(L);
    repeat (5) @(negedge clk);
  endtask

  task automatic enable_key();
    pulse(H, 6, 6); mids(7); pulse(H, 6, 6);
  endtask

  task automatic finish_run();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk) sup_lvl = 2'(L);
    repeat (6) @(negedge clk);
    chk("R9 reset code", fuse_code, 0);
    chk("R9 reset lock", fuse_lock, 0);
    chk("R10 reset addr", addr, 0);

    // R2 addressing, R1 qualification
    pulse(H, 6, 6); mids(5);
    chk("R2 addr after H+5M", addr, 6);
    pulse(M, 3, 6);
    chk("R1 short pulse discarded", addr, 6);
    pulse(M, 6, 2);
    chk("R1 valid pulse counted", addr, 7);
    pulse(M, 6, 6);
    chk("R1 pulse after short gap discarded", addr, 7);
    pulse(M, 6, 6);
    chk("R1 next pulse counted", addr, 8);
    drop();
    chk("R10 abort addr", addr, 0);

    // R3 polarity key
    pulse(H, 6, 6); mids(2); pulse(H, 6, 6);
    chk("R3 neg dir", addr_neg, 1);
    chk("R3 addr 1", addr, 1);
    mids(3);
    chk("R3 neg addressing", addr, 4);
    drop();
    chk("R10 abort dir", addr_neg, 0);

    // R4 enable, R6 code bit
    enable_key();
    chk("R4 enabled addr 0", addr, 0);
    pulse(H, 6, 6); mids(3);
    pulse(H, 25, 6);
    chk("R6 bit2 blown", fuse_code, 4);
    chk("R5 back to idle", addr, 0);

    // R5 addressing without enable never writes
    pulse(H, 6, 6); pulse(H, 25, 6);
    chk("R5 no write when not enabled", fuse_code, 4);
    chk("R5 long high only addresses", addr, 1);
    drop();

    // R6 non-power-of-two address
    enable_key(); pulse(H, 6, 6); mids(4);
    pulse(H, 25, 6);
    chk("R6 addr5 no write", fuse_code, 4);

    // R7 polarity fuse
    drop(); enable_key(); pulse(H, 25, 6);
    chk("R7 positive no pol write", fuse_pol, 0);
    drop();
    pulse(H, 6, 6); mids(1); pulse(H, 6, 6); mids(7); pulse(H, 6, 6);
    chk("R4 enable keeps neg dir", addr_neg, 1);
    pulse(H, 25, 6);
    chk("R7 pol fuse set", fuse_pol, 1);

    // R11 short high while enabled
    drop(); enable_key();
    pulse(H, 10, 6);
    chk("R11 short high selects addr", addr, 1);
    chk("R11 short high no write", fuse_code, 4);
    mids(1); pulse(H, 25, 6);
    chk("R6 bit1 blown", fuse_code, 6);

    // R8 lock at the top address
    drop(); enable_key(); pulse(H, 6, 6); mids(127);
    chk("R8 lock address reached", addr, 128);
    pulse(H, 25, 6);
    chk("R8 lock set", fuse_lock, 1);
    drop(); enable_key(); pulse(H, 6, 6); pulse(H, 25, 6);
    chk("R8 write after lock ignored", fuse_code, 6);

    // R9 sticky through abort
    drop();
    chk("R9 code kept", fuse_code, 6);
    chk("R9 pol kept", fuse_pol, 1);

    // R2 saturation
    pulse(H, 6, 6); mids(130);
    chk("R2 addr saturates", addr, 128);
    drop();

    finish_run();
  end
endmodule